// File: doc/BRIEF.md
# OTP Array and Option-Byte Access Port

This block is the device-side logic behind a byte-wide parallel programming port on a one-time-programmable memory. An external programmer drives six control lines and an 8-bit data bus. All of these are synchronised to the system clock inside the block. Before any access is possible, the programmer must play one of two edge-ordered entry preambles on the control lines. One preamble opens the main array and the other opens a single 8-bit option byte. Any edge that arrives out of order throws the recogniser back to its idle state, and the programmer must then start the preamble again from the beginning.

In array mode, a sequential address counter selects the byte. A clear pulse returns the counter to zero and each step pulse advances it by one. While the read-enable line is low, the port drives the stored byte. While the write line is low and the programming-voltage line is high, the incoming byte is ANDed into the stored byte, so a bit can only go from 1 (erased) to 0 (programmed). Option mode works the same way on the option byte, except that two reserved bits can never be cleared. Once a mode has been entered, it holds until reset, which stands in for power-on.

Top module: `otp_access_port`

## Requirements
- R1: After reset, `dout_en`, `dout`, `mode_array` and `mode_option` are all 0, every array byte reads 8'hFF, and the option byte reads 8'hFF.
- R2: The array preamble enters array mode (`mode_array`=1). It runs, one edge at a time: `sel_n` falls while every other line is at rest (`rd_n`=1, `hv_on`=0, `cnt_clr`=0, `cnt_step`=0, `wr_n`=1); `rd_n` falls; `hv_on` rises; `cnt_clr` rises; `cnt_clr` falls; `hv_on` falls; `hv_on` rises; `rd_n` rises; `sel_n` rises.
- R3: The option preamble enters option mode (`mode_option`=1). It runs: `sel_n` falls from rest; `hv_on` rises; `cnt_clr` rises; `cnt_clr` falls; `hv_on` falls; `hv_on` rises; then OPT_LOOPS (7) rounds of `cnt_step` rise, `rd_n` fall, `rd_n` rise, `cnt_step` fall; then `sel_n` rises.
- R4: Any edge other than the one expected next returns the recogniser to idle. Finishing the remaining steps afterwards enters no mode, and only a full restart of the preamble succeeds.
- R5: Within either preamble, if `hv_on` stays low for fewer than HV_GAP (200) clock cycles before it rises again, the recogniser aborts to idle.
- R6: In array mode, a rising `cnt_clr` sets the address to 0 and a rising `cnt_step` adds 1. The address wraps from 2^ADDR_W-1 to 0, and clear wins over step.
- R7: `dout_en` is 1 only while a mode is active and `rd_n` is low. It then carries the selected byte, with stored bit i on `dout[i]`. Otherwise `dout` is 0.
- R8: While `wr_n` is low and `hv_on` is high in array mode, the addressed byte becomes its old value AND `din`, so a written 1 never restores a 0. With `hv_on` low a write has no effect.
- R9: In option mode, writes AND `din` into the option byte, but bits 3 and 5 stay 1. The address counter plays no part.
- R10: Writes before any mode is entered have no effect. Once a mode is entered, no control activity leaves it before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| sel_n | input | 1 | Mode-select line, asynchronous |
| rd_n | input | 1 | Read enable, active low, asynchronous |
| hv_on | input | 1 | Programming-voltage present, asynchronous |
| cnt_clr | input | 1 | Address clear pulse, asynchronous |
| cnt_step | input | 1 | Address step pulse, asynchronous |
| wr_n | input | 1 | Program strobe, active low, asynchronous |
| din | input | 8 | Byte to program |
| dout | output | 8 | Byte read out, 0 when not driven |
| dout_en | output | 1 | Port drives `dout` |
| mode_array | output | 1 | Array mode active |
| mode_option | output | 1 | Option mode active |

## Verification
A recogniser stuck in the wrong state shows up directly on `mode_array` or `mode_option`: about three clocks after the final `sel_n` edge, the flag is either missing or appears when it should not. An address counter that is off by one or fails to wrap shows up on the next read as a byte written at a neighbouring location. Each test therefore programs distinct patterns at adjacent addresses. A broken AND rule or reserved-bit mask appears on the read that directly follows the write, as a bit that came back to 1 or a reserved bit at 0.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;

    localparam int unsigned NLINES = 6;

    // control line slots in the synchronised vector
    localparam int unsigned LN_SEL = 0;
    localparam int unsigned LN_RD  = 1;
    localparam int unsigned LN_HV  = 2;
    localparam int unsigned LN_CLR = 3;
    localparam int unsigned LN_STP = 4;
    localparam int unsigned LN_WR  = 5;

    // resting level of every line: sel_n=1, rd_n=1, wr_n=1, others 0
    localparam logic [NLINES-1:0] LINE_REST = 6'b100011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_W_HV_UP,
        ST_W_CLR_UP,
        ST_W_CLR_DN,
        ST_W_HV_DN,
        ST_W_HV_REUP,
        ST_W_RD_UP,
        ST_W_STP_UP,
        ST_W_RD_DN,
        ST_W_RD_UP_L,
        ST_W_STP_DN,
        ST_W_SEL_UP,
        ST_RUN
    } entry_st_e;

    typedef enum logic {
        PATH_ARRAY,
        PATH_OPTION
    } path_e;

endpackage

// File: rtl/otp_line_sync.sv
module otp_line_sync #(
    parameter int unsigned N       = 6,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = raw;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{s1: RST_VAL, s2: RST_VAL, prev: RST_VAL};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign lvl = sy_q.s2;

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = sy_q.s2[g] & ~sy_q.prev[g];
        assign fall[g] = ~sy_q.s2[g] & sy_q.prev[g];
    end

endmodule

// File: rtl/otp_entry_fsm.sv
module otp_entry_fsm
    import otp_port_pkg::*;
#(
    parameter int unsigned HV_GAP    = 200,
    parameter int unsigned OPT_LOOPS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl,
    input  logic [NLINES-1:0] rise,
    input  logic [NLINES-1:0] fall,
    output logic              run_array,
    output logic              run_option
);

    localparam int unsigned GAP_W  = $clog2(HV_GAP + 1);
    localparam int unsigned LOOP_W = $clog2(OPT_LOOPS + 1);
    localparam logic [NLINES-1:0] SEL_LOW_REST = LINE_REST & ~(NLINES'(1) << LN_SEL);

    typedef struct packed {
        entry_st_e          st;
        path_e              path;
        logic [GAP_W-1:0]   gap;
        logic [LOOP_W-1:0]  loops;
    } fsm_t;

    fsm_t fs_d, fs_q;

    logic [NLINES-1:0] exp_rise, exp_fall;
    logic              any_evt;
    logic              hit;

    // single edge awaited in each state
    always_comb begin
        exp_rise = '0;
        exp_fall = '0;
        unique case (fs_q.st)
            ST_IDLE:      exp_fall[LN_SEL] = 1'b1;
            ST_W_HV_UP:   exp_rise[LN_HV]  = 1'b1;
            ST_W_CLR_UP:  exp_rise[LN_CLR] = 1'b1;
            ST_W_CLR_DN:  exp_fall[LN_CLR] = 1'b1;
            ST_W_HV_DN:   exp_fall[LN_HV]  = 1'b1;
            ST_W_HV_REUP: exp_rise[LN_HV]  = 1'b1;
            ST_W_RD_UP:   exp_rise[LN_RD]  = 1'b1;
            ST_W_STP_UP:  exp_rise[LN_STP] = 1'b1;
            ST_W_RD_DN:   exp_fall[LN_RD]  = 1'b1;
            ST_W_RD_UP_L: exp_rise[LN_RD]  = 1'b1;
            ST_W_STP_DN:  exp_fall[LN_STP] = 1'b1;
            ST_W_SEL_UP:  exp_rise[LN_SEL] = 1'b1;
            default: ;
        endcase
    end

    assign any_evt = (|rise) | (|fall);
    assign hit     = any_evt && (rise == exp_rise) && (fall == exp_fall);

    always_comb begin
        fs_d = fs_q;
        unique case (fs_q.st)
            ST_RUN: ;
            ST_IDLE: begin
                if (hit && lvl == SEL_LOW_REST) begin
                    fs_d.st = ST_SPLIT;
                end
            end
            ST_SPLIT: begin
                if (any_evt) begin
                    if (rise == '0 && fall == (NLINES'(1) << LN_RD)) begin
                        fs_d.st   = ST_W_HV_UP;
                        fs_d.path = PATH_ARRAY;
                    end else if (fall == '0 && rise == (NLINES'(1) << LN_HV)) begin
                        fs_d.st   = ST_W_CLR_UP;
                        fs_d.path = PATH_OPTION;
                    end else begin
                        fs_d = '{st: ST_IDLE, path: PATH_ARRAY, gap: '0, loops: '0};
                    end
                end
            end
            default: begin
                if (any_evt && !hit) begin
                    fs_d = '{st: ST_IDLE, path: PATH_ARRAY, gap: '0, loops: '0};
                end else if (hit) begin
                    unique case (fs_q.st)
                        ST_W_HV_UP:  fs_d.st = ST_W_CLR_UP;
                        ST_W_CLR_UP: fs_d.st = ST_W_CLR_DN;
                        ST_W_CLR_DN: fs_d.st = ST_W_HV_DN;
                        ST_W_HV_DN: begin
                            fs_d.st  = ST_W_HV_REUP;
                            fs_d.gap = '0;
                        end
                        ST_W_HV_REUP: begin
                            if (fs_q.gap < GAP_W'(HV_GAP)) begin
                                fs_d = '{st: ST_IDLE, path: PATH_ARRAY, gap: '0, loops: '0};
                            end else if (fs_q.path == PATH_ARRAY) begin
                                fs_d.st = ST_W_RD_UP;
                            end else begin
                                fs_d.st    = ST_W_STP_UP;
                                fs_d.loops = '0;
                            end
                        end
                        ST_W_RD_UP:   fs_d.st = ST_W_SEL_UP;
                        ST_W_STP_UP:  fs_d.st = ST_W_RD_DN;
                        ST_W_RD_DN:   fs_d.st = ST_W_RD_UP_L;
                        ST_W_RD_UP_L: fs_d.st = ST_W_STP_DN;
                        ST_W_STP_DN: begin
                            if (fs_q.loops == LOOP_W'(OPT_LOOPS - 1)) begin
                                fs_d.st = ST_W_SEL_UP;
                            end else begin
                                fs_d.st    = ST_W_STP_UP;
                                fs_d.loops = fs_q.loops + 1'b1;
                            end
                        end
                        ST_W_SEL_UP: fs_d.st = ST_RUN;
                        default: ;
                    endcase
                end else if (fs_q.st == ST_W_HV_REUP && fs_q.gap < GAP_W'(HV_GAP)) begin
                    fs_d.gap = fs_q.gap + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= '{st: ST_IDLE, path: PATH_ARRAY, gap: '0, loops: '0};
        end else begin
            fs_q <= fs_d;
        end
    end

    assign run_array  = (fs_q.st == ST_RUN) && (fs_q.path == PATH_ARRAY);
    assign run_option = (fs_q.st == ST_RUN) && (fs_q.path == PATH_OPTION);

endmodule

// File: rtl/otp_cell_store.sv
module otp_cell_store #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] RSV_MASK = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              arr_we,
    input  logic              opt_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] opt_byte
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;
    logic [DATA_W-1:0] opt_d, opt_q;

    always_comb begin
        rd_d  = cells[addr];
        opt_d = opt_q;
        if (opt_we) begin
            opt_d = (opt_q & wdata) | RSV_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '1;
            opt_q <= '1;
        end else begin
            rd_q  <= rd_d;
            opt_q <= opt_d;
        end
    end

    // erased array; programming only clears bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (arr_we) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    assign arr_rdata = rd_q;
    assign opt_byte  = opt_q;

endmodule

// File: rtl/otp_access_port.sv
module otp_access_port
    import otp_port_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned HV_GAP    = 200,
    parameter int unsigned OPT_LOOPS = 7,
    parameter logic [DATA_W-1:0] RSV_MASK = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              hv_on,
    input  logic              cnt_clr,
    input  logic              cnt_step,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              mode_array,
    output logic              mode_option
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] d1;
        logic [DATA_W-1:0] d2;
    } port_t;

    port_t pt_d, pt_q;

    logic [NLINES-1:0] raw_lines, lvl, ev_rise, ev_fall;
    logic              run_array, run_option;
    logic              clr_up, stp_up;
    logic              arr_we, opt_we;
    logic [DATA_W-1:0] arr_rdata, opt_byte;
    logic [ADDR_W-1:0] cur_addr;

    assign raw_lines = {wr_n, cnt_step, cnt_clr, hv_on, rd_n, sel_n};

    otp_line_sync #(.N(NLINES), .RST_VAL(LINE_REST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_lines),
        .lvl  (lvl),
        .rise (ev_rise),
        .fall (ev_fall)
    );

    otp_entry_fsm #(.HV_GAP(HV_GAP), .OPT_LOOPS(OPT_LOOPS)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .rise      (ev_rise),
        .fall      (ev_fall),
        .run_array (run_array),
        .run_option(run_option)
    );

    assign clr_up = ev_rise[LN_CLR];
    assign stp_up = ev_rise[LN_STP];

    always_comb begin
        pt_d    = pt_q;
        pt_d.d1 = din;
        pt_d.d2 = pt_q.d1;
        if (run_array) begin
            if (clr_up) begin
                pt_d.addr = '0;
            end else if (stp_up) begin
                pt_d.addr = pt_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_q <= '{addr: '0, d1: '1, d2: '1};
        end else begin
            pt_q <= pt_d;
        end
    end

    assign cur_addr = pt_q.addr;
    assign arr_we   = run_array  & ~lvl[LN_WR] & lvl[LN_HV];
    assign opt_we   = run_option & ~lvl[LN_WR] & lvl[LN_HV];

    otp_cell_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSV_MASK(RSV_MASK)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cur_addr),
        .arr_we   (arr_we),
        .opt_we   (opt_we),
        .wdata    (pt_q.d2),
        .arr_rdata(arr_rdata),
        .opt_byte (opt_byte)
    );

    assign mode_array  = run_array;
    assign mode_option = run_option;
    assign dout_en     = (run_array | run_option) & ~lvl[LN_RD];
    assign dout        = dout_en ? (run_option ? opt_byte : arr_rdata) : '0;

endmodule

// File: rtl/otp_access_port_chk.sv
module otp_access_port_chk #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-1:0] RSV_MASK = 8'h28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_array,
    input logic              mode_option,
    input logic              dout_en,
    input logic              clr_up,
    input logic              stp_up,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [DATA_W-1:0] opt_byte
);

    p_sticky_arr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_array |=> mode_array);

    p_sticky_opt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_option |=> mode_option);

    p_drive_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (mode_array || mode_option));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_array && clr_up) |=> (cur_addr == '0));

    p_step_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_array && stp_up && !clr_up) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_array && (clr_up || stp_up)) |=> $stable(cur_addr));

    p_rsv_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((opt_byte & RSV_MASK) == RSV_MASK));

    p_opt_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((opt_byte & ~$past(opt_byte)) == '0));

endmodule

bind otp_access_port otp_access_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_array (mode_array),
    .mode_option(mode_option),
    .dout_en    (dout_en),
    .clr_up     (clr_up),
    .stp_up     (stp_up),
    .cur_addr   (cur_addr),
    .opt_byte   (opt_byte)
);

// File: tb/otp_access_port_tb.sv
module otp_access_port_tb;

    localparam int SEL = 0, RD = 1, HV = 2, CLR = 3, STP = 4, WR = 5;
    localparam int HOLD = 5;
    localparam int GOOD_GAP = 250;
    localparam int SHORT_GAP = 20;
    localparam int ADDR_W = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ctl = 6'b100011;
    logic [7:0] din = 8'hFF;
    logic [7:0] dout;
    logic       dout_en, mode_array, mode_option;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    otp_access_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .sel_n(ctl[SEL]), .rd_n(ctl[RD]), .hv_on(ctl[HV]),
        .cnt_clr(ctl[CLR]), .cnt_step(ctl[STP]), .wr_n(ctl[WR]),
        .din(din), .dout(dout), .dout_en(dout_en),
        .mode_array(mode_array), .mode_option(mode_option)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(int idx, logic v, int hold = HOLD);
        @(negedge clk);
        ctl[idx] = v;
        repeat (hold) @(negedge clk);
    endtask

    task automatic to_rest();
        if (ctl[CLR] != 1'b0) drive(CLR, 1'b0);
        if (ctl[STP] != 1'b0) drive(STP, 1'b0);
        if (ctl[WR]  != 1'b1) drive(WR, 1'b1);
        if (ctl[RD]  != 1'b1) drive(RD, 1'b1);
        if (ctl[HV]  != 1'b0) drive(HV, 1'b0);
        if (ctl[SEL] != 1'b1) drive(SEL, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctl = 6'b100011;
        din = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic array_preamble(int gap);
        drive(SEL, 1'b0); drive(RD, 1'b0); drive(HV, 1'b1);
        drive(CLR, 1'b1); drive(CLR, 1'b0);
        drive(HV, 1'b0, gap); drive(HV, 1'b1);
        drive(RD, 1'b1); drive(SEL, 1'b1);
    endtask

    task automatic option_preamble(int gap);
        drive(SEL, 1'b0); drive(HV, 1'b1);
        drive(CLR, 1'b1); drive(CLR, 1'b0);
        drive(HV, 1'b0, gap); drive(HV, 1'b1);
        for (int i = 0; i < 7; i++) begin
            drive(STP, 1'b1); drive(RD, 1'b0); drive(RD, 1'b1); drive(STP, 1'b0);
        end
        drive(SEL, 1'b1);
    endtask

    task automatic read_byte(output logic [7:0] val, output logic en);
        drive(RD, 1'b0);
        val = dout;
        en  = dout_en;
        drive(RD, 1'b1);
    endtask

    task automatic write_byte(logic [7:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(negedge clk);
        drive(WR, 1'b0, 6);
        drive(WR, 1'b1);
    endtask

    task automatic pulse_clear();
        drive(CLR, 1'b1); drive(CLR, 1'b0);
    endtask

    task automatic pulse_step(int hold = HOLD);
        drive(STP, 1'b1, hold); drive(STP, 1'b0, hold);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 dout_en", dout_en, 0);
        chk("R1 dout", dout, 0);
        chk("R1 mode_array", mode_array, 0);
        chk("R1 mode_option", mode_option, 0);
    endtask

    task automatic t_abort_and_gap();
        // R4: unexpected clear edge in place of hv rise, then finish the rest
        drive(SEL, 1'b0); drive(RD, 1'b0); drive(CLR, 1'b1);
        drive(HV, 1'b1); drive(CLR, 1'b0);
        drive(HV, 1'b0, GOOD_GAP); drive(HV, 1'b1);
        drive(RD, 1'b1); drive(SEL, 1'b1);
        chk("R4 abort array", mode_array, 0);
        chk("R4 abort option", mode_option, 0);
        to_rest();
        // R5: too short a programming-voltage gap
        array_preamble(SHORT_GAP);
        chk("R5 short gap", mode_array, 0);
        to_rest();
        option_preamble(SHORT_GAP);
        chk("R5 short gap option", mode_option, 0);
        to_rest();
    endtask

    task automatic t_array();
        logic [7:0] v;
        logic en;
        // R10: write before entry must be ignored
        drive(HV, 1'b1);
        write_byte(8'h00);
        drive(HV, 1'b0);
        array_preamble(GOOD_GAP);
        chk("R2 mode_array", mode_array, 1);
        chk("R2 mode_option", mode_option, 0);
        pulse_clear();
        chk("R7 idle dout_en", dout_en, 0);
        read_byte(v, en);
        chk("R7 dout_en on read", en, 1);
        chk("R10 pre-entry write ignored", v, 8'hFF);
        write_byte(8'hA5);
        read_byte(v, en);
        chk("R8 write A5", v, 8'hA5);
        write_byte(8'hF0);
        read_byte(v, en);
        chk("R8 and rule", v, 8'hA0);
        pulse_step();
        read_byte(v, en);
        chk("R6 step to addr1 erased", v, 8'hFF);
        write_byte(8'h3C);
        pulse_step();
        write_byte(8'h81);
        // R8: no programming voltage, no change
        drive(HV, 1'b0);
        write_byte(8'h00);
        drive(HV, 1'b1);
        read_byte(v, en);
        chk("R8 hv low ignored", v, 8'h81);
        pulse_clear();
        read_byte(v, en);
        chk("R6 clear to addr0", v, 8'hA0);
        pulse_step();
        read_byte(v, en);
        chk("R6 addr1", v, 8'h3C);
        // R10: control activity after entry does not leave the mode
        drive(SEL, 1'b0); drive(SEL, 1'b1);
        drive(CLR, 1'b1); drive(HV, 1'b0); drive(HV, 1'b1); drive(CLR, 1'b0);
        chk("R10 sticky array", mode_array, 1);
        // R6: wrap; from addr0, 2^ADDR_W steps return to addr0
        for (int i = 0; i < (1 << ADDR_W); i++) pulse_step(3);
        read_byte(v, en);
        chk("R6 wrap to addr0", v, 8'hA0);
        pulse_step();
        pulse_step();
        read_byte(v, en);
        chk("R6 addr2 after wrap", v, 8'h81);
    endtask

    task automatic t_option();
        logic [7:0] v;
        logic en;
        do_reset();
        option_preamble(GOOD_GAP);
        chk("R3 mode_option", mode_option, 1);
        chk("R3 mode_array", mode_array, 0);
        read_byte(v, en);
        chk("R1 option erased", v, 8'hFF);
        chk("R7 option dout_en", en, 1);
        write_byte(8'h00);
        read_byte(v, en);
        chk("R9 reserved bits kept", v, 8'h28);
        write_byte(8'hFF);
        pulse_step();
        pulse_clear();
        read_byte(v, en);
        chk("R9 no bit restored, address ignored", v, 8'h28);
        chk("R10 sticky option", mode_option, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_abort_and_gap();
        t_array();
        t_option();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule